// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits at a root port and takes in error messages sent up from the hierarchy below it. Each message has a severity (correctable, non-fatal or fatal) and a 16-bit requester source ID. The block folds each message into a root error status register. It records the source of the first correctable error and the first uncorrectable error in a shared source register. When an error of the same class arrives again, it sets a "multiple" flag and does not overwrite the recorded source.

A root command register holds one interrupt enable per severity. A mode input selects one of two signalling styles. In message mode, the block issues a single-cycle interrupt pulse each time the condition "some enabled severity is pending" goes from false to true. That transition can come from a new message or from software writing the command register. In legacy mode, the block drives an interrupt level that follows the same condition. The pulse carries a 5-bit interrupt message number. Software cannot write this number; it is loaded through a sideband input.

Software reaches the registers through a simple port: a 2-bit word address, a write strobe, write data, and combinational read data. Status bits are cleared by writing 1 to them.

Top module: `rp_err_collector`

## Requirements
- R1: After reset, the command, status and source registers all read zero, the message number is zero, and both interrupt outputs are low.
- R2: A message with severity code 0 (correctable) sets status bit 0. If bit 0 was already set, it sets bit 1 (multiple correctable) and leaves the source register's low 16 bits unchanged. Otherwise it stores the message source in those low 16 bits.
- R3: A message with severity code 1 (non-fatal) or 2 (fatal) sets status bit 2. If bit 2 was already set, it sets bit 3 (multiple uncorrectable) and leaves the source register's high 16 bits unchanged. Otherwise it stores the source in those high 16 bits.
- R4: A fatal message always sets status bit 6. It also sets bit 4 (first fatal), but only when bit 2 was clear before the message. A non-fatal message sets status bit 5.
- R5: A message with severity code 3 is ignored. It changes no register and raises no interrupt.
- R6: Writing word 1 clears each status bit 6..0 whose write-data bit is 1; zeros in the write data leave the bits alone. Decisions about first versus multiple use the status as it stood before the cycle. A bit set by a message in the same cycle as a clear stays set.
- R7: In message mode (msi_mode=1), msi_pulse is high for one cycle, the cycle after a message is accepted, when two conditions hold. First, the command enable for that severity is set (severity code n maps to command bit n). Second, before the message, no enabled received bit was pending. The received bits 0, 5 and 6 map to command bits 0, 1 and 2.
- R8: In message mode, a write to word 0 (command bits 2..0) produces msi_pulse in the following cycle. This happens only if the old command masked by the mapped status was zero and the new command masked by the mapped status is nonzero.
- R9: In legacy mode (msi_mode=0), intx_level equals whether the command masked by the mapped status is nonzero, and msi_pulse stays low.
- R10: The interrupt message number reads in status bits 31..27 and drives msi_vector. It changes only when vec_ld is high, taking vec_in; software writes to those bits have no effect.
- R11: Word 0 stores only bits 2..0 of the write data, and all its other bits read zero. Word 2 is read-only, and word 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | 1 selects message-interrupt signalling, 0 selects legacy level |
| msg_valid | input | 1 | An error message is presented this cycle |
| msg_sev | input | 2 | Message severity: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msg_src | input | 16 | Requester source ID of the message |
| reg_addr | input | 2 | Register word address: 0 command, 1 status, 2 source |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| vec_ld | input | 1 | Load strobe for the interrupt message number |
| vec_in | input | 5 | Sideband interrupt message number |
| msi_pulse | output | 1 | One-cycle message interrupt request |
| msi_vector | output | 5 | Message number to accompany msi_pulse |
| intx_level | output | 1 | Legacy interrupt level |

## Verification
Repeated messages of one class against the same status distinguish first-error capture from multiple-error flagging. The repeats use differing source IDs, so an overwritten source register shows up directly. Fatal messages are sent both with and without a non-fatal error already pending, which separates the first-fatal rule from plain fatal reception. Same-cycle clears and messages show the clear-versus-set priority. Interrupt tests toggle enables before and after status bits become pending, which tells edge-triggered pulses apart from level behaviour and from the command-write path. A long random stretch mixing every input is then compared cycle by cycle against the reference model.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;

  localparam int ST_W   = 7;
  localparam int EN_W   = 3;
  localparam int ST_COR  = 0;
  localparam int ST_MCOR = 1;
  localparam int ST_UNC  = 2;
  localparam int ST_MUNC = 3;
  localparam int ST_FFAT = 4;
  localparam int ST_NF   = 5;
  localparam int ST_FAT  = 6;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_SRC  = 2'd2;

  // Received bits folded onto the command enable positions.
  function automatic logic [EN_W-1:0] stat_to_en(input logic [ST_W-1:0] st);
    return {st[ST_FAT], st[ST_NF], st[ST_COR]};
  endfunction

  // Enable bit that a message of a given severity is gated by.
  function automatic logic [EN_W-1:0] sev_to_en(input logic [1:0] sev);
    logic [EN_W-1:0] r;
    case (sev)
      SEV_COR:      r = 3'b001;
      SEV_NONFATAL: r = 3'b010;
      SEV_FATAL:    r = 3'b100;
      default:      r = 3'b000;
    endcase
    return r;
  endfunction

  // Status bits a message sets, judged against the pre-message status.
  function automatic logic [ST_W-1:0] status_set(input logic [ST_W-1:0] st,
                                                 input logic [1:0] sev);
    logic [ST_W-1:0] s;
    s = '0;
    if (sev == SEV_COR) begin
      s[ST_COR] = 1'b1;
      if (st[ST_COR]) s[ST_MCOR] = 1'b1;
    end else if (sev == SEV_NONFATAL || sev == SEV_FATAL) begin
      s[ST_UNC] = 1'b1;
      if (st[ST_UNC]) s[ST_MUNC] = 1'b1;
      if (sev == SEV_FATAL) begin
        s[ST_FAT] = 1'b1;
        if (!st[ST_UNC]) s[ST_FFAT] = 1'b1;
      end else begin
        s[ST_NF] = 1'b1;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/rp_err_status.sv
module rp_err_status
  import rp_err_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_acc,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             clr_we,
  input  logic [ST_W-1:0]  clr_mask,
  output logic [ST_W-1:0]  stat_q,
  output logic [SRC_W-1:0] src_cor_q,
  output logic [SRC_W-1:0] src_unc_q,
  output logic             ev_cap_cor,
  output logic             ev_cap_unc
);

  logic [ST_W-1:0] set_bits;
  logic [ST_W-1:0] clr_bits;
  logic            is_cor;
  logic            is_unc;

  always_comb begin
    is_cor     = msg_acc && (msg_sev == SEV_COR);
    is_unc     = msg_acc && (msg_sev == SEV_NONFATAL || msg_sev == SEV_FATAL);
    set_bits   = msg_acc ? status_set(stat_q, msg_sev) : '0;
    clr_bits   = clr_we ? clr_mask : '0;
    ev_cap_cor = is_cor && !stat_q[ST_COR];
    ev_cap_unc = is_unc && !stat_q[ST_UNC];
  end

  // One write-1-to-clear flop per status bit; a same-cycle set wins.
  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)            stat_q[b] <= 1'b0;
      else if (set_bits[b])  stat_q[b] <= 1'b1;
      else if (clr_bits[b])  stat_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_cor_q <= '0;
      src_unc_q <= '0;
    end else begin
      if (ev_cap_cor) src_cor_q <= msg_src;
      if (ev_cap_unc) src_unc_q <= msg_src;
    end
  end

endmodule

// File: rtl/rp_err_cmd.sv
module rp_err_cmd
  import rp_err_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [EN_W-1:0]  cmd_wdata,
  input  logic             vec_ld,
  input  logic [VEC_W-1:0] vec_in,
  output logic [EN_W-1:0]  cmd_q,
  output logic [VEC_W-1:0] vec_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= cmd_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_ld) vec_q <= vec_in;
  end

endmodule

// File: rtl/rp_err_irq.sv
module rp_err_irq
  import rp_err_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msi_mode,
  input  logic [ST_W-1:0] stat_q,
  input  logic [EN_W-1:0] cmd_q,
  input  logic            cmd_we,
  input  logic [EN_W-1:0] cmd_wdata,
  input  logic            msg_acc,
  input  logic [1:0]      msg_sev,
  output logic            msi_pulse,
  output logic            intx_level,
  output logic            ev_msg_irq,
  output logic            ev_cmd_irq
);

  logic [EN_W-1:0] rcv_en;
  logic [EN_W-1:0] pend_en;
  logic            pend_any;
  logic            pulse_d;

  always_comb begin
    rcv_en     = stat_to_en(stat_q);
    pend_en    = rcv_en & cmd_q;
    pend_any   = |pend_en;
    ev_msg_irq = msg_acc && (|(sev_to_en(msg_sev) & cmd_q)) && !pend_any;
    ev_cmd_irq = cmd_we && !pend_any && (|(cmd_wdata & rcv_en));
    pulse_d    = msi_mode && (ev_msg_irq || ev_cmd_irq);
    intx_level = !msi_mode && pend_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) msi_pulse <= 1'b0;
    else        msi_pulse <= pulse_d;
  end

endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
  import rp_err_pkg::*;
#(
  parameter  int SRC_W  = 16,
  parameter  int VEC_W  = 5,
  localparam int DATA_W = 2 * SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_mode,
  input  logic              msg_valid,
  input  logic [1:0]        msg_sev,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vec_ld,
  input  logic [VEC_W-1:0]  vec_in,
  output logic              msi_pulse,
  output logic [VEC_W-1:0]  msi_vector,
  output logic              intx_level
);

  localparam int PAD_W = DATA_W - VEC_W - ST_W;

  logic             msg_acc;
  logic             cmd_we;
  logic             clr_we;
  logic [ST_W-1:0]  stat_q;
  logic [SRC_W-1:0] src_cor_q;
  logic [SRC_W-1:0] src_unc_q;
  logic [EN_W-1:0]  cmd_q;
  logic [VEC_W-1:0] vec_q;
  logic             ev_cap_cor;
  logic             ev_cap_unc;
  logic             ev_msg_irq;
  logic             ev_cmd_irq;

  always_comb begin
    msg_acc = msg_valid && (msg_sev != SEV_RSVD);
    cmd_we  = reg_wr && (reg_addr == ADDR_CMD);
    clr_we  = reg_wr && (reg_addr == ADDR_STAT);
  end

  rp_err_status #(.SRC_W(SRC_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_acc   (msg_acc),
    .msg_sev   (msg_sev),
    .msg_src   (msg_src),
    .clr_we    (clr_we),
    .clr_mask  (reg_wdata[ST_W-1:0]),
    .stat_q    (stat_q),
    .src_cor_q (src_cor_q),
    .src_unc_q (src_unc_q),
    .ev_cap_cor(ev_cap_cor),
    .ev_cap_unc(ev_cap_unc)
  );

  rp_err_cmd #(.VEC_W(VEC_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_wdata(reg_wdata[EN_W-1:0]),
    .vec_ld   (vec_ld),
    .vec_in   (vec_in),
    .cmd_q    (cmd_q),
    .vec_q    (vec_q)
  );

  rp_err_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_mode  (msi_mode),
    .stat_q    (stat_q),
    .cmd_q     (cmd_q),
    .cmd_we    (cmd_we),
    .cmd_wdata (reg_wdata[EN_W-1:0]),
    .msg_acc   (msg_acc),
    .msg_sev   (msg_sev),
    .msi_pulse (msi_pulse),
    .intx_level(intx_level),
    .ev_msg_irq(ev_msg_irq),
    .ev_cmd_irq(ev_cmd_irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CMD:  reg_rdata = {{(DATA_W-EN_W){1'b0}}, cmd_q};
      ADDR_STAT: reg_rdata = {vec_q, {PAD_W{1'b0}}, stat_q};
      ADDR_SRC:  reg_rdata = {src_unc_q, src_cor_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign msi_vector = vec_q;

endmodule

// File: rtl/rp_err_collector_chk.sv
module rp_err_collector_chk
  import rp_err_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msi_mode,
  input logic             msi_pulse,
  input logic             intx_level,
  input logic [ST_W-1:0]  stat_q,
  input logic [EN_W-1:0]  cmd_q,
  input logic [SRC_W-1:0] src_cor_q,
  input logic [SRC_W-1:0] src_unc_q,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic             reg_wr,
  input logic [1:0]       reg_addr
);

  logic pend_now;
  assign pend_now = |(stat_to_en(stat_q) & cmd_q);

  AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(msi_mode) |-> !msi_pulse) else $error("legacy pulse"); // R9

  AST_LEVEL_ONLY_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    intx_level |-> !msi_mode) else $error("level in msg mode"); // R9

  AST_MULTI_COR_NEEDS_COR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_MCOR]) |-> stat_q[ST_COR]) else $error("multi cor"); // R2

  AST_COR_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_COR] |=> $stable(src_cor_q)) else $error("cor src moved"); // R2

  AST_UNC_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_UNC] |=> $stable(src_unc_q)) else $error("unc src moved"); // R3

  AST_FIRST_FATAL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_FFAT]) |-> (stat_q[ST_FAT] && !$past(stat_q[ST_UNC])))
    else $error("first fatal"); // R4

  AST_PULSE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> !$past(pend_now)) else $error("pulse without edge"); // R7

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_RSVD && !(reg_wr && reg_addr == ADDR_STAT))
      |=> $stable(stat_q)) else $error("reserved msg acted"); // R5

endmodule

bind rp_err_collector rp_err_collector_chk #(.SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msi_mode  (msi_mode),
  .msi_pulse (msi_pulse),
  .intx_level(intx_level),
  .stat_q    (stat_q),
  .cmd_q     (cmd_q),
  .src_cor_q (src_cor_q),
  .src_unc_q (src_unc_q),
  .msg_valid (msg_valid),
  .msg_sev   (msg_sev),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr)
);

// File: tb/rp_err_collector_tb_top.sv
`timescale 1ns/1ps
module rp_err_collector_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // Driven values (d_) and staged values for the next cycle (b_).
  logic        d_mode = 0, d_v = 0, d_wr = 0, d_ld = 0;
  logic [1:0]  d_sev = 0, d_addr = 1;
  logic [15:0] d_src = 0;
  logic [31:0] d_wdata = 0;
  logic [4:0]  d_vin = 0;
  logic        b_mode = 0, b_v = 0, b_wr = 0, b_ld = 0;
  logic [1:0]  b_sev = 0, b_addr = 1;
  logic [15:0] b_src = 0;
  logic [31:0] b_wdata = 0;
  logic [4:0]  b_vin = 0;

  logic [31:0] reg_rdata;
  logic        msi_pulse, intx_level;
  logic [4:0]  msi_vector;

  rp_err_collector dut_i (
    .clk(clk), .rst_n(rst_n), .msi_mode(d_mode), .msg_valid(d_v),
    .msg_sev(d_sev), .msg_src(d_src), .reg_addr(d_addr), .reg_wr(d_wr),
    .reg_wdata(d_wdata), .reg_rdata(reg_rdata), .vec_ld(d_ld),
    .vec_in(d_vin), .msi_pulse(msi_pulse), .msi_vector(msi_vector),
    .intx_level(intx_level)
  );

  // Reference model state
  logic [6:0]  m_stat = 0;
  logic [2:0]  m_cmd = 0;
  logic [15:0] m_srcc = 0, m_srcu = 0;
  logic [4:0]  m_vec = 0;
  logic        m_pulse = 0;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic logic [2:0] rcv_of(input logic [6:0] s);
    logic [2:0] e;
    e[0] = s[0]; e[1] = s[5]; e[2] = s[6];
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    if (a == 2'd0) return {29'd0, m_cmd};
    if (a == 2'd1) return {m_vec, 20'd0, m_stat};
    if (a == 2'd2) return {m_srcu, m_srcc};
    return 32'd0;
  endfunction

  task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check1("msi_pulse", {31'd0, msi_pulse}, {31'd0, m_pulse});
    check1("intx_level", {31'd0, intx_level},
           {31'd0, (!d_mode && ((rcv_of(m_stat) & m_cmd) != 0))});
    check1("msi_vector", {27'd0, msi_vector}, {27'd0, m_vec});
    check1("reg_rdata", reg_rdata, exp_rd(d_addr));
  endtask

  task automatic model_step();
    logic       acc, msgirq, cmdirq;
    logic [6:0] setb, clrb;
    logic [2:0] pend;
    int         sv;
    sv   = d_sev;
    acc  = d_v && (d_sev != 2'd3);
    setb = 0;
    if (acc) begin
      if (sv == 0) begin
        setb[0] = 1;
        if (m_stat[0]) setb[1] = 1;
      end else begin
        setb[2] = 1;
        if (m_stat[2]) setb[3] = 1;
        if (sv == 2) begin
          setb[6] = 1;
          if (!m_stat[2]) setb[4] = 1;
        end else setb[5] = 1;
      end
    end
    pend   = rcv_of(m_stat) & m_cmd;
    msgirq = acc && m_cmd[sv] && (pend == 0);
    cmdirq = d_wr && (d_addr == 0) && (pend == 0) &&
             ((d_wdata[2:0] & rcv_of(m_stat)) != 0);
    m_pulse = d_mode && (msgirq || cmdirq);
    if (acc && sv == 0 && !m_stat[0]) m_srcc = d_src;
    if (acc && sv != 0 && !m_stat[2]) m_srcu = d_src;
    clrb   = (d_wr && d_addr == 1) ? d_wdata[6:0] : 7'd0;
    m_stat = (m_stat & ~clrb) | setb;
    if (d_wr && d_addr == 0) m_cmd = d_wdata[2:0];
    if (d_ld) m_vec = d_vin;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    d_mode = b_mode; d_v = b_v; d_sev = b_sev; d_src = b_src; d_addr = b_addr;
    d_wr = b_wr; d_wdata = b_wdata; d_ld = b_ld; d_vin = b_vin;
    model_step();
    @(posedge clk);
    b_v = 0; b_wr = 0; b_ld = 0;
  endtask

  task automatic msg(input logic [1:0] s, input logic [15:0] id);
    b_v = 1; b_sev = s; b_src = id; tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    b_wr = 1; b_addr = a; b_wdata = v; tick();
  endtask

  task automatic idle(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) begin b_addr = a; tick(); end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state of all words and outputs
    cur_req = "R1";
    idle(2'd0, 1); idle(2'd1, 1); idle(2'd2, 1); idle(2'd3, 1);
    // R10: sideband message number, software write ignored
    cur_req = "R10";
    b_ld = 1; b_vin = 5'd19; idle(2'd1, 2);
    wr(2'd1, 32'hF800_0000); idle(2'd1, 1);
    // R11: only command bits 2..0 stored; word 2 read-only
    cur_req = "R11";
    wr(2'd0, 32'hFFFF_FFFF); idle(2'd0, 1);
    wr(2'd0, 32'h0); wr(2'd2, 32'h1234_5678); idle(2'd2, 1);
    // R2: first correctable captured, second flagged multiple
    cur_req = "R2";
    msg(2'd0, 16'h1234); idle(2'd2, 1);
    msg(2'd0, 16'hBEEF); idle(2'd2, 1); idle(2'd1, 1);
    // R3 / R4: non-fatal then fatal
    cur_req = "R3";
    msg(2'd1, 16'h0A0A); idle(2'd2, 1);
    cur_req = "R4";
    msg(2'd2, 16'h0F0F); idle(2'd1, 1); idle(2'd2, 1);
    // R6: clearing, zero write, same-cycle priority
    cur_req = "R6";
    wr(2'd1, 32'h0000_0000); idle(2'd1, 1);
    wr(2'd1, 32'h0000_007F); idle(2'd1, 1);
    b_v = 1; b_sev = 2'd2; b_src = 16'h7777; wr(2'd1, 32'h7F); idle(2'd1, 1);
    idle(2'd2, 1);
    msg(2'd0, 16'h0001);
    b_v = 1; b_sev = 2'd0; b_src = 16'h0002; wr(2'd1, 32'h7F); idle(2'd1, 1);
    wr(2'd1, 32'h7F);
    // R5: reserved severity ignored
    cur_req = "R5";
    b_mode = 1; wr(2'd0, 32'h7);
    msg(2'd3, 16'hDEAD); idle(2'd1, 2);
    // R7: message-driven pulse only on first enabled pending
    cur_req = "R7";
    msg(2'd0, 16'h0100); idle(2'd1, 2);
    msg(2'd1, 16'h0200); idle(2'd1, 2);
    wr(2'd1, 32'h7F); wr(2'd0, 32'h1);
    msg(2'd2, 16'h0300); idle(2'd1, 2);
    // R8: command write edge
    cur_req = "R8";
    wr(2'd0, 32'h4); idle(2'd0, 2);
    wr(2'd0, 32'h4); idle(2'd0, 2);
    wr(2'd0, 32'h0); wr(2'd0, 32'h6); idle(2'd0, 1);
    // R9: legacy level follows command and status
    cur_req = "R9";
    b_mode = 0; wr(2'd0, 32'h0); idle(2'd1, 1);
    wr(2'd0, 32'h4); idle(2'd1, 2);
    msg(2'd0, 16'h0400); idle(2'd1, 1);
    wr(2'd0, 32'h0); idle(2'd1, 1);
    wr(2'd0, 32'h1); wr(2'd1, 32'h1); idle(2'd1, 2);
    // R7: random mix compared every cycle
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      b_mode  = ($urandom_range(0, 7) != 0);
      b_v     = ($urandom_range(0, 2) == 0);
      b_sev   = 2'($urandom_range(0, 3));
      b_src   = 16'($urandom);
      b_wr    = ($urandom_range(0, 3) == 0);
      b_addr  = 2'($urandom_range(0, 3));
      b_wdata = $urandom;
      b_ld    = ($urandom_range(0, 15) == 0);
      b_vin   = 5'($urandom);
      tick();
    end
    idle(2'd1, 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule